// File: doc/BRIEF.md
# Railed-PWM Fault Rotation Controller

This block supervises the fine-control PWM that regulates a solar-array power bus. A PWM whose duty cycle sits at a hard rail is treated as failed. The rails are fully off and fully on. The fault only counts while the arrays are lit. A 1 Hz tick paces a persistence timer. When the railed condition outlasts a programmable number of ticks, the block hands control to the next redundant side and PWM combination.

There are four combinations, tried in a fixed order. The first move swaps to the second PWM on the same side. The second move crosses to the other side using its first PWM. The third move swaps to that side's second PWM. If the last combination also times out, the block raises an exhausted flag and holds where it is. It never wraps back by itself. A ground command can load any of the four combinations directly, and this also clears the exhausted flag.

The control PWM and the in-sun detection are outside this block. It only sees a duty value and a sun-valid level.

Top module: `rail_pwm_rotator`

## Requirements
- R1: After reset, step_o is 0, side_sel_o is 0 (side A), pwm_sel_o is 0 (PWM 1), exhausted_o is 0 and railed_o is 0.
- R2: railed_o goes high one clock after duty_i equals 0 or equals DUTY_FULL while sun_ok_i is high. It is low one clock after any other duty value, or after sun_ok_i is low.
- R3: A reassignment happens only on the (FAULT_TICKS+1)-th consecutive tick_i pulse that samples railed_o high. Any clock in which railed_o is low clears the count, so a reassignment needs a fresh run.
- R4: The step code maps to outputs as follows: 0 is side A with PWM 1, 1 is side A with PWM 2, 2 is side B with PWM 1, and 3 is side B with PWM 2. side_sel_o is 0 for A and 1 for B; pwm_sel_o is 0 for PWM 1 and 1 for PWM 2. Each timeout advances the code by exactly one.
- R5: After each reassignment the persistence count restarts from zero.
- R6: A timeout at step 3 sets exhausted_o and leaves step_o at 3. While exhausted, further railed ticks change nothing.
- R7: A cmd_load_i pulse loads cmd_step_i into step_o on the next clock. It also clears exhausted_o and the persistence count. It wins over a timeout in the same clock.
- R8: Without cmd_load_i, step_o and exhausted_o change only on a clock where tick_i is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock pulse at 1 Hz pacing the persistence timer |
| duty_i | input | DUTY_W | Duty-cycle code of the active control PWM |
| sun_ok_i | input | 1 | High while the arrays are illuminated |
| cmd_load_i | input | 1 | Ground command strobe that loads a step |
| cmd_step_i | input | 2 | Step code to load with cmd_load_i |
| side_sel_o | output | 1 | Active side: 0 for A, 1 for B |
| pwm_sel_o | output | 1 | Active PWM on that side: 0 for PWM 1, 1 for PWM 2 |
| step_o | output | 2 | Current step code in the rotation |
| exhausted_o | output | 1 | All four combinations have timed out |
| railed_o | output | 1 | Registered railed-while-lit condition |

## Verification
The assertions take for granted that tick_i is a single-clock pulse. They also assume that cmd_load_i and tick_i are synchronous levels that change only between clock edges. The properties therefore tie every step or flag change to a command, or to a tick that sees the registered railed flag. The stimulus drives all inputs on the falling edge and holds tick_i high for exactly one clock. Before any tick, it leaves two clocks after each duty or sun change so the registered detector has settled. The sweep covers every duty code of a 4-bit configuration, both with and without sun, and uses a persistence limit of three ticks.

// File: rtl/rpfr_pkg.sv
package rpfr_pkg;

   typedef enum logic [1:0] {
      STEP_A_P1 = 2'd0,
      STEP_A_P2 = 2'd1,
      STEP_B_P1 = 2'd2,
      STEP_B_P2 = 2'd3
   } step_e;

   localparam logic [1:0] STEP_LAST = 2'd3;

   function automatic logic side_of(input logic [1:0] s);
      return (s == STEP_B_P1) || (s == STEP_B_P2);
   endfunction

   function automatic logic pwm_of(input logic [1:0] s);
      return (s == STEP_A_P2) || (s == STEP_B_P2);
   endfunction

endpackage

// File: rtl/rpfr_rail_detect.sv
module rpfr_rail_detect #(
   parameter int          DUTY_W    = 10,
   parameter int unsigned DUTY_FULL = 1023,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DUTY_W-1:0] duty_i,
   input  logic              sun_ok_i,
   output logic              railed_o
);
   localparam logic [DUTY_W-1:0] FULL_CODE = DUTY_W'(DUTY_FULL);

   logic at_rail;

   always_comb begin
      at_rail = sun_ok_i && ((duty_i == '0) || (duty_i == FULL_CODE));
   end

   generate
      if (REG_OUT) begin : g_reg
         logic railed_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) railed_q <= 1'b0;
            else        railed_q <= at_rail;
         end
         assign railed_o = railed_q;
      end else begin : g_comb
         assign railed_o = at_rail;
      end
   endgenerate
endmodule

// File: rtl/rpfr_persist_timer.sv
module rpfr_persist_timer #(
   parameter int unsigned FAULT_TICKS = 300
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic fault_i,
   input  logic clear_i,
   output logic expire_o
);
   localparam int CNT_W = $clog2(FAULT_TICKS + 1);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(FAULT_TICKS);

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      expire_o = tick_i && fault_i && !clear_i && (cnt_q == LIM);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i || !fault_i || expire_o) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q != LIM)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rpfr_step_seq.sv
module rpfr_step_seq
   import rpfr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire_i,
   input  logic       cmd_load_i,
   input  logic [1:0] cmd_step_i,
   output logic [1:0] step_o,
   output logic       exhausted_o
);
   logic [1:0] step_q;
   logic       exh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= STEP_A_P1;
         exh_q  <= 1'b0;
      end else if (cmd_load_i) begin
         step_q <= cmd_step_i;
         exh_q  <= 1'b0;
      end else if (expire_i && !exh_q) begin
         if (step_q == STEP_LAST) exh_q  <= 1'b1;
         else                     step_q <= step_q + 2'd1;
      end
   end

   assign step_o      = step_q;
   assign exhausted_o = exh_q;
endmodule

// File: rtl/rail_pwm_rotator.sv
module rail_pwm_rotator
   import rpfr_pkg::*;
#(
   parameter int          DUTY_W      = 10,
   parameter int unsigned DUTY_FULL   = 1023,
   parameter int unsigned FAULT_TICKS = 300,
   parameter bit          REG_DETECT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [DUTY_W-1:0] duty_i,
   input  logic              sun_ok_i,
   input  logic              cmd_load_i,
   input  logic [1:0]        cmd_step_i,
   output logic              side_sel_o,
   output logic              pwm_sel_o,
   output logic [1:0]        step_o,
   output logic              exhausted_o,
   output logic              railed_o
);
   generate
      if (DUTY_W < 2) begin : g_bad_w
         $error("DUTY_W must be at least 2");
      end
      if (DUTY_FULL == 0 || DUTY_FULL > (2 ** DUTY_W) - 1) begin : g_bad_full
         $error("DUTY_FULL must be nonzero and fit in DUTY_W bits");
      end
      if (FAULT_TICKS < 1) begin : g_bad_ticks
         $error("FAULT_TICKS must be at least 1");
      end
   endgenerate

   logic expire;
   logic tmr_clear;

   rpfr_rail_detect #(
      .DUTY_W   (DUTY_W),
      .DUTY_FULL(DUTY_FULL),
      .REG_OUT  (REG_DETECT)
   ) det_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .duty_i  (duty_i),
      .sun_ok_i(sun_ok_i),
      .railed_o(railed_o)
   );

   assign tmr_clear = cmd_load_i || exhausted_o;

   rpfr_persist_timer #(
      .FAULT_TICKS(FAULT_TICKS)
   ) tmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .fault_i (railed_o),
      .clear_i (tmr_clear),
      .expire_o(expire)
   );

   rpfr_step_seq seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire_i   (expire),
      .cmd_load_i (cmd_load_i),
      .cmd_step_i (cmd_step_i),
      .step_o     (step_o),
      .exhausted_o(exhausted_o)
   );

   always_comb begin
      side_sel_o = side_of(step_o);
      pwm_sel_o  = pwm_of(step_o);
   end
endmodule

// File: rtl/rpfr_chk.sv
module rpfr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_i,
   input logic       sun_ok_i,
   input logic       cmd_load_i,
   input logic [1:0] cmd_step_i,
   input logic [1:0] step_o,
   input logic       exhausted_o,
   input logic       railed_o
);
   // R2
   no_rail_in_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sun_ok_i |=> !railed_o);

   // R3
   no_move_unrailed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_load_i && !railed_o) |=> $stable(step_o));

   // R4
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_load_i |=> (step_o == $past(step_o)) || (step_o == $past(step_o) + 2'd1));

   // R6
   exhausted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exhausted_o && !cmd_load_i) |=> (exhausted_o && step_o == 2'd3));

   // R7
   cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_load_i |=> (step_o == $past(cmd_step_i)) && !exhausted_o);

   // R8
   tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_load_i && !tick_i) |=> ($stable(step_o) && $stable(exhausted_o)));
endmodule

bind rail_pwm_rotator rpfr_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_i     (tick_i),
   .sun_ok_i   (sun_ok_i),
   .cmd_load_i (cmd_load_i),
   .cmd_step_i (cmd_step_i),
   .step_o     (step_o),
   .exhausted_o(exhausted_o),
   .railed_o   (railed_o)
);

// File: tb/rail_pwm_rotator_tb_top.sv
module rail_pwm_rotator_tb_top;
   localparam int W    = 4;
   localparam int FULL = 15;
   localparam int LIM  = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic [W-1:0] duty = 4'd7;
   logic         sun = 1'b0;
   logic         cmd_load = 1'b0;
   logic [1:0]   cmd_step = 2'd0;
   logic         side_sel, pwm_sel, exhausted, railed;
   logic [1:0]   step;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   rail_pwm_rotator #(
      .DUTY_W(W), .DUTY_FULL(FULL), .FAULT_TICKS(LIM), .REG_DETECT(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .duty_i(duty), .sun_ok_i(sun),
      .cmd_load_i(cmd_load), .cmd_step_i(cmd_step), .side_sel_o(side_sel),
      .pwm_sel_o(pwm_sel), .step_o(step), .exhausted_o(exhausted), .railed_o(railed)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      idle(2);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) pulse_tick();
   endtask

   task automatic load(input logic [1:0] s);
      @(negedge clk); cmd_load = 1'b1; cmd_step = s;
      @(negedge clk); cmd_load = 1'b0;
   endtask

   task automatic set_in(input int d, input logic s);
      @(negedge clk); duty = W'(d); sun = s;
      idle(2);
   endtask

   task automatic chk_step(input string req, input int exp);
      chk(req, step, exp);
      chk(req, side_sel, (exp >> 1) & 1);
      chk(req, pwm_sel, exp & 1);
   endtask

   initial begin
      #(200000 * 10);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      // R1 reset state
      chk_step("R1", 0);
      chk("R1", exhausted, 0);
      chk("R1", railed, 0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      // R2 detector response
      set_in(0, 1'b1);  chk("R2", railed, 1);
      set_in(15, 1'b1); chk("R2", railed, 1);
      set_in(15, 1'b0); chk("R2", railed, 0);
      set_in(1, 1'b1);  chk("R2", railed, 0);

      // R3 strictly longer than limit, then R4 full chain and R5 restart
      set_in(0, 1'b1);
      ticks(LIM);     chk_step("R3", 0);
      ticks(1);       chk_step("R4", 1);
      ticks(LIM);     chk_step("R5", 1);
      ticks(1);       chk_step("R4", 2);
      set_in(15, 1'b1);
      ticks(LIM + 1); chk_step("R4", 3);
      chk("R6", exhausted, 0);
      ticks(LIM + 1); chk_step("R6", 3);
      chk("R6", exhausted, 1);
      ticks(3 * LIM); chk_step("R6", 3);
      chk("R6", exhausted, 1);

      // R7 load clears exhausted
      load(2'd0);
      chk_step("R7", 0);
      chk("R7", exhausted, 0);

      // R3 dropout clears count
      load(2'd1);
      set_in(0, 1'b1); ticks(LIM);
      set_in(8, 1'b1); set_in(0, 1'b1);
      ticks(LIM);     chk_step("R3", 1);
      ticks(1);       chk_step("R3", 2);
      // R3 sun loss also clears
      load(2'd0);
      set_in(0, 1'b1); ticks(LIM);
      set_in(0, 1'b0); set_in(0, 1'b1);
      ticks(LIM);     chk_step("R3", 0);
      ticks(1);       chk_step("R3", 1);

      // R7 command wins over coincident timeout and clears count
      load(2'd0);
      set_in(15, 1'b1); ticks(LIM);
      @(negedge clk); tick = 1'b1; cmd_load = 1'b1; cmd_step = 2'd2;
      @(negedge clk); tick = 1'b0; cmd_load = 1'b0;
      idle(1);
      chk_step("R7", 2);
      ticks(LIM);     chk_step("R7", 2);
      ticks(1);       chk_step("R7", 3);

      // R7 each load value
      for (int s = 0; s < 4; s++) begin
         load(2'(s));
         chk_step("R7", s);
      end

      // R8 no change without tick while railed for long time
      load(2'd0);
      set_in(0, 1'b1);
      idle(50);
      chk_step("R8", 0);

      // R2 R3 sweep over all duty codes and sun levels
      for (int s = 0; s < 2; s++) begin
         for (int d = 0; d < 16; d++) begin
            bit rail;
            rail = (s == 1) && (d == 0 || d == FULL);
            load(2'd0);
            set_in(d, s[0]);
            chk("R2", railed, int'(rail));
            ticks(LIM);
            chk_step("R3", 0);
            ticks(1);
            chk_step("R3", rail ? 1 : 0);
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule